// File: doc/BRIEF.md
# SPI Word Buffer with Watermark Flags

This block buffers the 16-bit data path between a CPU-facing register interface and an SPI shift engine. A transmit queue collects words that the CPU pushes and hands them to the shifter on request. A receive queue collects words that the shifter delivers and hands them to the CPU on request. A small control register selects the buffering mode, two watermark thresholds and two watermark interrupt enables. Status flags and one combined interrupt line report the state of both queues.

With buffering mode off, each direction holds a single word, as a plain data buffer does. With buffering mode on, each direction holds four 16-bit words (64 bits). The full and empty flags then report a completely full or empty queue. Two watermark flags, each with its own threshold select and interrupt enable, let the CPU service the queues in bursts rather than word by word. Occupancy is counted in bits, as sixteen times the number of stored words.

Top module: `spi_fifo_buf`

## Requirements
- R1: After reset the control register reads 0x00, the transmit-empty flag is 1, the receive-full, both watermark and both overflow flags are 0, and `irq` is 0 while `txe_ie` and `rxf_ie` are low.
- R2: Control bit 0 turns buffering mode on. Bit 1 enables the receive-watermark interrupt and bit 2 the transmit-watermark interrupt. Bit 3 is a stored interrupt-clear mode bit. Bit 4 selects the receive watermark and bit 5 the transmit watermark. Bits 7:6 read 0. Bit 0 is always writable; bits 5:1 take a write only while bit 0 is already 1.
- R3: In buffering mode each queue holds four words and returns them oldest first. A push to a full queue is dropped and sets that queue's sticky overflow flag.
- R4: With buffering mode off each queue holds one word. A second push is dropped and sets the overflow flag, and `rx_full` is 1 once the receive queue holds its one word.
- R5: `tx_empty` is 1 exactly when the transmit queue holds no word. In buffering mode `rx_full` is 1 only when the receive queue holds four words.
- R6: `tx_near_empty` is 1 in buffering mode when the transmit queue holds 16 bits or fewer (bit 5 = 0) or 32 bits or fewer (bit 5 = 1). It is 0 with buffering mode off.
- R7: `rx_near_full` is 1 in buffering mode when the receive queue holds 48 bits or more (bit 4 = 0) or 32 bits or more (bit 4 = 1). It is 0 with buffering mode off.
- R8: `irq` is the OR of four terms: `rx_full` and `rxf_ie`, `tx_empty` and `txe_ie`, `tx_near_empty` and control bit 2, `rx_near_full` and control bit 1.
- R9: A CPU pop from an empty receive queue leaves `rx_data` unchanged and moves nothing. A shifter pop from an empty transmit queue is ignored.
- R10: A write that clears bit 0 while buffering mode is on empties both queues and clears both overflow flags in the same clock edge.
- R11: `rx_data` shows the oldest stored word from the clock edge that accepts a CPU pop. It holds that value until the next accepted pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| tx_push | input | 1 | CPU pushes a transmit word |
| tx_data | input | 16 | Transmit word from CPU |
| rx_pop | input | 1 | CPU pops a receive word |
| rx_data | output | 16 | Last popped receive word |
| sh_tx_pop | input | 1 | Shifter takes the oldest transmit word |
| sh_tx_data | output | 16 | Oldest transmit word |
| sh_rx_push | input | 1 | Shifter delivers a receive word |
| sh_rx_data | input | 16 | Received word from shifter |
| txe_ie | input | 1 | Interrupt enable for transmit-empty |
| rxf_ie | input | 1 | Interrupt enable for receive-full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive full (mode dependent) |
| tx_near_empty | output | 1 | Transmit watermark reached |
| rx_near_full | output | 1 | Receive watermark reached |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the register lock. Bits 5:1 must be shown to ignore a write that arrives while buffering mode is off. They must then take the very next write once bit 0 has been set by an earlier write. The stimulus first writes all ones with the mode off, then writes all ones again, and reads the register after each write. A second hard case is the flush that comes with leaving buffering mode. The bench reaches it only after both queues are partly filled and both overflow flags are set, so that every piece of state the flush clears is visibly non-zero beforehand.

// File: rtl/sfb_pkg.sv
// Shared types for the SPI word buffer.
// Assumes: control fields are packed from bit 5 down to bit 0.
package sfb_pkg;
    typedef struct packed {
        logic tx_mark;   // bit 5: transmit watermark select
        logic rx_mark;   // bit 4: receive watermark select
        logic int_clr;   // bit 3: interrupt-clear mode (stored only)
        logic ne_ie;     // bit 2: transmit watermark interrupt enable
        logic nf_ie;     // bit 1: receive watermark interrupt enable
        logic fifo_on;   // bit 0: buffering mode
    } ctrl_t;
endpackage

// File: rtl/sfb_ctrl.sv
// Control register: bit 0 always writable, bits 5:1 writable only while
// bit 0 is already set. Emits a flush pulse when buffering mode is left.
// Assumes: one write strobe per cycle, synchronous active-low reset.
module sfb_ctrl
    import sfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl,
    output logic       flush
);
    logic [5:0] bits_q;

    // Register update with the lock on the upper fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr) begin
            if (bits_q[0]) bits_q <= wdata[5:0];
            else           bits_q[0] <= wdata[0];
        end
    end

    assign ctrl  = ctrl_t'(bits_q);
    // Leaving buffering mode empties both queues.
    assign flush = wr && bits_q[0] && !wdata[0];

    p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !bits_q[0]) |=> (bits_q[5:1] == $past(bits_q[5:1])));
    p_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (bits_q[0] == $past(wdata[0])));
endmodule

// File: rtl/sfb_fifo.sv
// Word queue with a run-time capacity limit, sticky overflow and flush.
// Assumes: DEPTH >= 2; cap never exceeds DEPTH; pops on empty are ignored.
module sfb_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (count < cap) && !flush;
    assign do_pop  = pop && (count != '0) && !flush;
    assign head    = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer, occupancy and overflow tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
            if (push && !do_push) ovf <= 1'b1;
        end
    end

    p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && count >= cap) |=> (count == $past(count) && ovf));
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0));
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !ovf));
endmodule

// File: rtl/sfb_flags.sv
// Flag and interrupt logic derived from the current occupancy.
// Assumes: occupancy counts are in words; thresholds are given in bits.
module sfb_flags
    import sfb_pkg::*;
#(
    parameter int W          = 16,
    parameter int DEPTH      = 4,
    parameter int TX_LO_BITS = 16,
    parameter int TX_HI_BITS = 32,
    parameter int RX_LO_BITS = 32,
    parameter int RX_HI_BITS = 48,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int BITS_W    = $clog2(DEPTH * W + 1)
) (
    input  ctrl_t            ctrl,
    input  logic             txe_ie,
    input  logic             rxf_ie,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             tx_near_empty,
    output logic             rx_near_full,
    output logic             irq
);
    logic [BITS_W-1:0] tx_bits, rx_bits;

    // Occupancy in bits and the four level flags.
    always_comb begin
        tx_bits       = BITS_W'(tx_cnt) * BITS_W'(W);
        rx_bits       = BITS_W'(rx_cnt) * BITS_W'(W);
        tx_empty      = (tx_cnt == '0);
        rx_full       = ctrl.fifo_on ? (rx_cnt == CNT_W'(DEPTH)) : (rx_cnt != '0);
        tx_near_empty = ctrl.fifo_on &&
            (tx_bits <= BITS_W'(ctrl.tx_mark ? TX_LO_BITS * 2 : TX_LO_BITS));
        rx_near_full  = ctrl.fifo_on &&
            (rx_bits >= BITS_W'(ctrl.rx_mark ? RX_LO_BITS : RX_HI_BITS));
    end

    // Combined interrupt request.
    assign irq = (rx_full && rxf_ie) || (tx_empty && txe_ie) ||
                 (tx_near_empty && ctrl.ne_ie) || (rx_near_full && ctrl.nf_ie);

    initial assert (TX_HI_BITS == 2 * TX_LO_BITS);
endmodule

// File: rtl/spi_fifo_buf.sv
// SPI word buffer top: control register, transmit and receive queues,
// and flag/interrupt logic. Capacity is four words in buffering mode and
// one word otherwise. rx_data is registered on an accepted CPU pop.
// Assumes: synchronous active-low reset; all strobes are single-cycle.
module spi_fifo_buf
    import sfb_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [7:0]   cfg_wdata,
    output logic [7:0]   cfg_rdata,
    input  logic         tx_push,
    input  logic [W-1:0] tx_data,
    input  logic         rx_pop,
    output logic [W-1:0] rx_data,
    input  logic         sh_tx_pop,
    output logic [W-1:0] sh_tx_data,
    input  logic         sh_rx_push,
    input  logic [W-1:0] sh_rx_data,
    input  logic         txe_ie,
    input  logic         rxf_ie,
    output logic         tx_empty,
    output logic         rx_full,
    output logic         tx_near_empty,
    output logic         rx_near_full,
    output logic         tx_ovf,
    output logic         rx_ovf,
    output logic         irq
);
    ctrl_t            ctrl;
    logic             flush;
    logic [CNT_W-1:0] cap, tx_cnt, rx_cnt;
    logic [W-1:0]     rx_head;

    sfb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .ctrl(ctrl), .flush(flush)
    );

    assign cfg_rdata = {2'b00, 6'(ctrl)};
    assign cap       = ctrl.fifo_on ? CNT_W'(DEPTH) : CNT_W'(1);

    sfb_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(tx_push), .din(tx_data), .pop(sh_tx_pop),
        .head(sh_tx_data), .count(tx_cnt), .ovf(tx_ovf)
    );

    sfb_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(sh_rx_push), .din(sh_rx_data), .pop(rx_pop),
        .head(rx_head), .count(rx_cnt), .ovf(rx_ovf)
    );

    sfb_flags #(.W(W), .DEPTH(DEPTH)) u_flags (
        .ctrl(ctrl), .txe_ie(txe_ie), .rxf_ie(rxf_ie),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_empty(tx_empty), .rx_full(rx_full),
        .tx_near_empty(tx_near_empty), .rx_near_full(rx_near_full),
        .irq(irq)
    );

    // Capture the oldest receive word on an accepted CPU pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rx_data <= '0;
        else if (rx_pop && rx_cnt != '0 && !flush) rx_data <= rx_head;
    end

    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |=> $stable(rx_data));
    p_rx_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_cnt != '0 && !flush) |=> (rx_data == $past(rx_head)));
    p_single_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.fifo_on && !cfg_wr) |=> (tx_cnt <= CNT_W'(1) && rx_cnt <= CNT_W'(1)));
endmodule

// File: tb/test_spi_fifo_buf.sv
module test_spi_fifo_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        tx_push = 1'b0;
    logic [15:0] tx_data = '0;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_data;
    logic        sh_tx_pop = 1'b0;
    logic [15:0] sh_tx_data;
    logic        sh_rx_push = 1'b0;
    logic [15:0] sh_rx_data = '0;
    logic        txe_ie = 1'b0, rxf_ie = 1'b0;
    logic        tx_empty, rx_full, tx_near_empty, rx_near_full, tx_ovf, rx_ovf, irq;

    always #2.5 clk = ~clk;   // 200 MHz

    spi_fifo_buf i_spi_fifo_buf (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_push(tx_push), .tx_data(tx_data),
        .rx_pop(rx_pop), .rx_data(rx_data), .sh_tx_pop(sh_tx_pop),
        .sh_tx_data(sh_tx_data), .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
        .txe_ie(txe_ie), .rxf_ie(rxf_ie), .tx_empty(tx_empty), .rx_full(rx_full),
        .tx_near_empty(tx_near_empty), .rx_near_full(rx_near_full),
        .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] txq[$];
    logic [15:0] rxq[$];
    logic [5:0]  ctrl_m = '0;
    logic        exp_tx_ovf = 0, exp_rx_ovf = 0;
    logic [15:0] exp_rx_data = '0;

    function automatic int cap_m();
        return ctrl_m[0] ? 4 : 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        cyc();
        cfg_wr = 1'b0;
        if (ctrl_m[0]) begin
            if (!v[0]) begin
                txq.delete(); rxq.delete();
                exp_tx_ovf = 0; exp_rx_ovf = 0;
            end
            ctrl_m = v[5:0];
        end else begin
            ctrl_m[0] = v[0];
        end
    endtask

    // Driver: CPU transmit push, expected item queued if there is room.
    task automatic cpu_push(input logic [15:0] d);
        tx_push = 1'b1; tx_data = d;
        cyc();
        tx_push = 1'b0;
        if (txq.size() < cap_m()) txq.push_back(d); else exp_tx_ovf = 1;
        chk("R3/R4 tx_ovf", tx_ovf, exp_tx_ovf);
    endtask

    // Driver: shifter receive push.
    task automatic shf_push(input logic [15:0] d);
        sh_rx_push = 1'b1; sh_rx_data = d;
        cyc();
        sh_rx_push = 1'b0;
        if (rxq.size() < cap_m()) rxq.push_back(d); else exp_rx_ovf = 1;
        chk("R3/R4 rx_ovf", rx_ovf, exp_rx_ovf);
    endtask

    // Monitor: shifter side pop, compared against the transmit scoreboard.
    task automatic shf_pop();
        if (txq.size() > 0) chk("R3 sh_tx_data order", sh_tx_data, txq.pop_front());
        sh_tx_pop = 1'b1;
        cyc();
        sh_tx_pop = 1'b0;
        chk("R5 tx_empty", tx_empty, txq.size() == 0);
    endtask

    // Monitor: CPU receive pop, compared against the receive scoreboard.
    task automatic cpu_pop();
        rx_pop = 1'b1;
        cyc();
        rx_pop = 1'b0;
        if (rxq.size() > 0) exp_rx_data = rxq.pop_front();
        chk("R11/R9 rx_data", rx_data, exp_rx_data);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 cfg_rdata", cfg_rdata, 8'h00);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 near flags", {tx_near_empty, rx_near_full}, 0);
        chk("R1 ovf flags", {tx_ovf, rx_ovf}, 0);
        chk("R1 irq", irq, 0);

        // R4 single-entry mode
        cpu_push(16'hA001);
        chk("R5 tx_empty after push", tx_empty, 0);
        cpu_push(16'hA002);
        chk("R6 near-empty off outside mode", tx_near_empty, 0);
        shf_pop();
        shf_push(16'hB001);
        chk("R4 rx_full single word", rx_full, 1);
        chk("R7 near-full off outside mode", rx_near_full, 0);
        shf_push(16'hB002);
        cpu_pop();

        // R2 register lock and field map
        wr_ctrl(8'h3E);
        chk("R2 locked write", cfg_rdata, 8'h00);
        wr_ctrl(8'hFF);
        chk("R2 only bit0 taken", cfg_rdata, 8'h01);
        wr_ctrl(8'hFF);
        chk("R2 full write, 7:6 zero", cfg_rdata, 8'h3F);
        chk("R10 overflow held before flush", {tx_ovf, rx_ovf}, 2'b11);
        wr_ctrl(8'h00);
        chk("R10 flush clears ovf", {tx_ovf, rx_ovf}, 2'b00);
        chk("R2 mode off", cfg_rdata, 8'h00);
        wr_ctrl(8'h01);
        chk("R2 mode on", cfg_rdata, 8'h01);

        // R3 / R6 transmit queue, watermark 16 bits
        for (int i = 0; i < 4; i++) begin
            cpu_push(16'hC000 + 16'(i));
            chk("R6 near-empty mark0", tx_near_empty, (i + 1) <= 1);
        end
        cpu_push(16'hC0FF);
        wr_ctrl(8'h21);
        chk("R6 near-empty mark1 at 4", tx_near_empty, 0);
        for (int i = 0; i < 4; i++) begin
            shf_pop();
            chk("R6 near-empty mark1", tx_near_empty, (3 - i) <= 2);
        end

        // R3 / R5 / R7 receive queue, watermark 48 bits
        wr_ctrl(8'h01);
        for (int i = 0; i < 4; i++) begin
            shf_push(16'hD000 + 16'(i));
            chk("R7 near-full mark0", rx_near_full, (i + 1) >= 3);
            chk("R5 rx_full only at four", rx_full, (i + 1) == 4);
        end
        shf_push(16'hD0FF);
        wr_ctrl(8'h11);
        for (int i = 0; i < 4; i++) begin
            cpu_pop();
            chk("R7 near-full mark1", rx_near_full, (3 - i) >= 2);
        end
        cpu_pop();   // R9: empty pop keeps last word
        chk("R9 rx_data held", rx_data, 16'hD003);
        sh_tx_pop = 1'b1; cyc(); sh_tx_pop = 1'b0;
        chk("R9 empty tx pop ignored", tx_empty, 1);
        cpu_push(16'hE001);
        chk("R9 head after empty pop", sh_tx_data, 16'hE001);

        // R8 interrupt combination
        chk("R8 irq idle", irq, 0);
        wr_ctrl(8'h15);
        chk("R8 irq near-empty", irq, 1);
        cpu_push(16'hE002);
        chk("R8 irq near-empty gone", irq, 0);
        txe_ie = 1'b1;
        cyc();
        chk("R8 txe_ie not empty", irq, 0);
        shf_pop();
        shf_pop();
        chk("R8 irq tx_empty", irq, 1);
        txe_ie = 1'b0;
        wr_ctrl(8'h11);
        chk("R8 irq all disabled", irq, 0);
        wr_ctrl(8'h13);
        shf_push(16'hF001);
        chk("R8 irq below rx mark", irq, 0);
        shf_push(16'hF002);
        chk("R8 irq near-full", irq, 1);
        wr_ctrl(8'h11);
        shf_push(16'hF003);
        shf_push(16'hF004);
        chk("R8 irq full without enable", irq, 0);
        rxf_ie = 1'b1;
        cyc();
        chk("R8 irq rx_full", irq, 1);
        rxf_ie = 1'b0;

        // R10 flush with data in both queues
        cpu_push(16'hF101);
        shf_push(16'hF0FF);
        chk("R10 rx_ovf before flush", rx_ovf, 1);
        wr_ctrl(8'h00);
        chk("R10 tx flushed", tx_empty, 1);
        chk("R10 rx flushed", rx_full, 0);
        chk("R10 ovf cleared", {tx_ovf, rx_ovf}, 0);
        cpu_pop();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule